// File: doc/BRIEF.md
# Stack Frame Push/Pop Sequencer

This block takes one 16-bit compressed stack-frame instruction for a 32-bit RISC-V core and turns it into a timed series of word-wide memory accesses and register-file writes. It handles five variants. Two build a frame: a plain push, and a push that also points the frame pointer at the caller's stack top. Three tear a frame down: a plain pop, a pop that returns, and a pop that returns with a zero result.

The saved list always begins with the return address (x1). It continues with s0 (x8), s1 (x9), and then s2 to s11 (x18 to x27). Slots are filled from the top of the frame downward in that order. The stack pointer comes from `sp_in`. The store data comes from a combinational register-file read port that the block addresses. Loaded words, the frame-pointer or a0 value and the new stack pointer all go out through a single register-file write port. After the last memory access, the block writes the stack pointer, pulses `done` and, for the return variants, presents the restored return address as a jump target.

The stack-pointer and frame-pointer updates are held back until every memory access has completed. An instruction is therefore never seen half-committed at the register file.

Top module: `frame_seq`

## Requirements
- R1: An instruction is accepted only if bits [1:0] are 2'b10 and bits [15:8] hold one of these values: 8'hB8 push, 8'hB9 push with frame pointer, 8'hBA pop, 8'hBC pop-return-zero, 8'hBE pop-return. Any other value raises `illegal` for one cycle, in the cycle after `start`, and causes no access and no register write.
- R2: Register-list field values 0 to 3 in bits [7:4] are rejected as illegal.
- R3: When `c_enable` is low, every instruction is rejected as illegal.
- R4: The register count is 13 when the list field is 15, and the field minus 3 otherwise. The registers are taken in the order x1, x8, x9, x18, x19, and so on, so field 14 ends at x25 and field 15 ends at x27.
- R5: Push stores the k-th listed register (k counted from 0) at old_sp − 4·(k+1). It then writes x2 = old_sp − frame.
- R6: The frame size is the register count times 4, rounded up to a multiple of 16. Bits [3:2] add 16 bytes per unit on top of that.
- R7: Pop sets new_sp = old_sp + frame. It loads the k-th listed register from new_sp − 4·(k+1) and then writes x2 = new_sp.
- R8: Push with frame pointer does the same stores as push and also writes x8 with old_sp.
- R9: Pop-return and pop-return-zero assert `jump_valid`, with `jump_target` equal to the restored x1, in the `done` cycle. Pop-return-zero also writes 0 to x10. A plain pop never asserts `jump_valid`.
- R10: Each completed valid/ready handshake performs exactly one access. While `mem_ready` is low, the request is held unchanged. The x2 write happens only after the last access.
- R11: `done` is high for exactly one cycle per instruction. `start` is ignored while `busy` is high.
- R12: A synchronous reset returns the block to idle at once, with no memory request pending, and no later stack-pointer write from the aborted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction present; taken when idle |
| instr | input | 16 | Compressed instruction word |
| c_enable | input | 1 | Compressed instructions enabled |
| sp_in | input | 32 | Current stack pointer |
| rf_raddr | output | 5 | Register-file read address for store data |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request; read data valid in the same cycle |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| jump_valid | output | 1 | Return jump requested |
| jump_target | output | 32 | Restored return address |

## Verification
Push is tried with a two-register list plus extra space, with the full thirteen-register list, and with the eleven-register list. Together these separate the rounding of the frame size, the extra-space term and the skip over x26/x27. Pop is run with three registers plus extra space and with the full list. A one-register return pair checks the jump target and the a0 clear. Plain pop shows that no jump leaks out. The full push is repeated with an alternating `mem_ready` to show that a stall adds no accesses and does not move the stack-pointer write ahead of the final access. Separate stimuli cover a reserved list value, a wrong opcode byte, wrong low bits, a disabled compressed extension, a start attempt while busy, and a reset in the middle of an instruction.

// File: rtl/frame_pkg.sv
package frame_pkg;

    localparam int RF_AW   = 5;
    localparam int CNT_W   = 4;
    localparam int FRAME_W = 8;

    typedef enum logic [2:0] {
        OP_PUSH,
        OP_PUSHFP,
        OP_POP,
        OP_POPRET,
        OP_POPRETZ
    } frame_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_EXTRA,
        ST_COMMIT
    } frame_st_e;

    typedef struct packed {
        logic               legal;
        frame_op_e          op;
        logic [CNT_W-1:0]   count;
        logic [FRAME_W-1:0] frame_bytes;
    } frame_dec_t;

    // k-th entry of the save list -> architectural register number
    function automatic logic [RF_AW-1:0] slot_reg(input logic [CNT_W-1:0] k);
        logic [RF_AW-1:0] r;
        case (k)
            4'd0:    r = 5'd1;
            4'd1:    r = 5'd8;
            4'd2:    r = 5'd9;
            default: r = RF_AW'(k) + 5'd15;
        endcase
        return r;
    endfunction

    function automatic logic is_store_op(input frame_op_e op);
        return (op == OP_PUSH) || (op == OP_PUSHFP);
    endfunction

endpackage

// File: rtl/frame_decode.sv
module frame_decode
    import frame_pkg::*;
(
    input  logic [15:0] instr,
    input  logic        c_enable,
    output frame_dec_t  dec
);
    logic             pat_ok;
    frame_op_e        op;
    logic [3:0]       rlist;
    logic [CNT_W-1:0] cnt;
    logic [FRAME_W-1:0] raw, base, extra;

    always_comb begin
        pat_ok = 1'b1;
        op     = OP_PUSH;
        case (instr[15:8])
            8'hB8:   op = OP_PUSH;
            8'hB9:   op = OP_PUSHFP;
            8'hBA:   op = OP_POP;
            8'hBC:   op = OP_POPRETZ;
            8'hBE:   op = OP_POPRET;
            default: pat_ok = 1'b0;
        endcase
        rlist = instr[7:4];
        cnt   = (rlist == 4'd15) ? 4'd13 : (rlist - 4'd3);
        raw   = {2'b00, cnt, 2'b00} + 8'd15;
        base  = {raw[7:4], 4'b0000};
        extra = {2'b00, instr[3:2], 4'b0000};

        dec.legal       = c_enable && (instr[1:0] == 2'b10) && pat_ok && (rlist >= 4'd4);
        dec.op          = op;
        dec.count       = cnt;
        dec.frame_bytes = base + extra;
    end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import frame_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  frame_dec_t       dec,
    input  logic [XLEN-1:0]  sp_in,
    output logic [RF_AW-1:0] rf_raddr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             rf_we,
    output logic [RF_AW-1:0] rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             jump_valid,
    output logic [XLEN-1:0]  jump_target
);
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

    frame_st_e        st;
    frame_op_e        op_q;
    logic [CNT_W-1:0] cnt_q, idx_q;
    logic [XLEN-1:0]  addr_q, sp_old_q, sp_new_q, ra_q;
    logic             illegal_q;

    logic [XLEN-1:0] frame_x, top_x;
    logic            new_store, last_xfer, xfer;

    always_comb begin
        frame_x   = XLEN'(dec.frame_bytes);
        new_store = is_store_op(dec.op);
        top_x     = new_store ? sp_in : (sp_in + frame_x);
        xfer      = (st == ST_XFER) && mem_ready;
        last_xfer = xfer && (idx_q == cnt_q - 4'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op_q      <= OP_PUSH;
            cnt_q     <= '0;
            idx_q     <= '0;
            addr_q    <= '0;
            sp_old_q  <= '0;
            sp_new_q  <= '0;
            ra_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    if (dec.legal) begin
                        op_q     <= dec.op;
                        cnt_q    <= dec.count;
                        idx_q    <= '0;
                        sp_old_q <= sp_in;
                        sp_new_q <= new_store ? (sp_in - frame_x) : (sp_in + frame_x);
                        addr_q   <= top_x - WORD_BYTES;
                        st       <= ST_XFER;
                    end else begin
                        illegal_q <= 1'b1;
                    end
                end
                ST_XFER: if (xfer) begin
                    addr_q <= addr_q - WORD_BYTES;
                    idx_q  <= idx_q + 4'd1;
                    if (!is_store_op(op_q) && idx_q == '0)
                        ra_q <= mem_rdata;
                    if (last_xfer)
                        st <= (op_q == OP_PUSHFP || op_q == OP_POPRETZ) ? ST_EXTRA : ST_COMMIT;
                end
                ST_EXTRA:  st <= ST_COMMIT;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_valid = (st == ST_XFER);
        mem_we    = is_store_op(op_q);
        mem_addr  = addr_q;
        rf_raddr  = slot_reg(idx_q);
        mem_wdata = rf_rdata;

        rf_we    = 1'b0;
        rf_waddr = '0;
        rf_wdata = '0;
        case (st)
            ST_XFER: begin
                rf_we    = xfer && !is_store_op(op_q);
                rf_waddr = slot_reg(idx_q);
                rf_wdata = mem_rdata;
            end
            ST_EXTRA: begin
                rf_we    = 1'b1;
                rf_waddr = (op_q == OP_PUSHFP) ? 5'd8 : 5'd10;
                rf_wdata = (op_q == OP_PUSHFP) ? sp_old_q : '0;
            end
            ST_COMMIT: begin
                rf_we    = 1'b1;
                rf_waddr = 5'd2;
                rf_wdata = sp_new_q;
            end
            default: ;
        endcase

        busy        = (st != ST_IDLE);
        done        = (st == ST_COMMIT);
        jump_valid  = done && (op_q == OP_POPRET || op_q == OP_POPRETZ);
        jump_target = ra_q;
        illegal     = illegal_q;
    end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      instr,
    input  logic             c_enable,
    input  logic [XLEN-1:0]  sp_in,
    output logic [4:0]       rf_raddr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             rf_we,
    output logic [4:0]       rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             jump_valid,
    output logic [XLEN-1:0]  jump_target
);
    frame_dec_t dec;

    frame_decode u_dec (
        .instr    (instr),
        .c_enable (c_enable),
        .dec      (dec)
    );

    frame_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .dec         (dec),
        .sp_in       (sp_in),
        .rf_raddr    (rf_raddr),
        .rf_rdata    (rf_rdata),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .mem_valid   (mem_valid),
        .mem_ready   (mem_ready),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .done        (done),
        .illegal     (illegal),
        .jump_valid  (jump_valid),
        .jump_target (jump_target)
    );
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [15:0]     instr,
    input logic            c_enable,
    input logic [XLEN-1:0] sp_in,
    input logic [4:0]      rf_raddr,
    input logic [XLEN-1:0] rf_rdata,
    input logic            rf_we,
    input logic [4:0]      rf_waddr,
    input logic [XLEN-1:0] rf_wdata,
    input logic            mem_valid,
    input logic            mem_ready,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic [XLEN-1:0] mem_rdata,
    input logic            busy,
    input logic            done,
    input logic            illegal,
    input logic            jump_valid,
    input logic [XLEN-1:0] jump_target
);
    a_r10_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    a_r10_sp_after_access: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !(rf_we && rf_waddr == 5'd2));

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_valid && !rf_we));

    a_r9_jump_in_done: assert property (@(posedge clk) disable iff (rst)
        jump_valid |-> done);

    a_r1_illegal_idle: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !busy);
endmodule

bind frame_seq frame_seq_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/frame_seq_test.sv
module frame_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        c_enable = 1'b1;
    logic [31:0] sp_in, rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata, jump_target;
    logic [4:0]  rf_raddr, rf_waddr;
    logic        rf_we, mem_valid, mem_ready, mem_we, busy, done, illegal, jump_valid;

    logic [31:0] rf_m [32];
    logic [31:0] mem_m [64];
    logic        stall = 1'b0;
    logic        tgl = 1'b0;

    int cyc = 0, acc_n = 0, done_n = 0, jump_n = 0, sp_wr_cyc = 0, last_acc_cyc = 0;
    logic [31:0] acc_addr [16];
    logic [31:0] jump_seen;
    int checks = 0, fails = 0;

    assign sp_in     = rf_m[2];
    assign rf_rdata  = rf_m[rf_raddr];
    assign mem_rdata = mem_m[mem_addr[7:2]];
    assign mem_ready = stall ? tgl : 1'b1;

    frame_seq uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tgl <= ~tgl;
        if (mem_valid && mem_ready) begin
            if (acc_n < 16) acc_addr[acc_n] <= mem_addr;
            acc_n <= acc_n + 1;
            last_acc_cyc <= cyc;
            if (mem_we) mem_m[mem_addr[7:2]] <= mem_wdata;
        end
        if (rf_we && rf_waddr != 5'd0) begin
            rf_m[rf_waddr] <= rf_wdata;
            if (rf_waddr == 5'd2) sp_wr_cyc <= cyc;
        end
        if (done) done_n <= done_n + 1;
        if (jump_valid) begin
            jump_n <= jump_n + 1;
            jump_seen <= jump_target;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] slot(input int k);
        if (k == 0) return 5'd1;
        if (k == 1) return 5'd8;
        if (k == 2) return 5'd9;
        return 5'(k + 15);
    endfunction

    function automatic int frame_of(input int n, input int ext);
        return ((n * 4 + 15) / 16) * 16 + ext * 16;
    endfunction

    task automatic preset(input logic [31:0] sp);
        @(negedge clk);
        for (int i = 0; i < 32; i++) rf_m[i] = 32'hA000_0000 + 32'(i * 32'h111);
        rf_m[0] = '0;
        rf_m[2] = sp;
        for (int i = 0; i < 64; i++) mem_m[i] = 32'h5000_0000 + 32'(i * 32'h1001);
        acc_n = 0; done_n = 0; jump_n = 0; sp_wr_cyc = 0; last_acc_cyc = 0;
    endtask

    task automatic issue(input logic [15:0] w, output logic ill);
        @(negedge clk);
        instr = w;
        start = 1'b1;
        @(posedge clk); #1;
        ill = illegal;
        start = 1'b0;
    endtask

    task automatic finish_op();
        int n = 0;
        while (busy && n < 500) begin
            @(posedge clk); #1;
            n++;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk(!busy && !mem_valid && !done && !illegal && !rf_we, "R12 reset idle",
            {27'b0, busy, mem_valid, done, illegal, rf_we}, 32'h0);
    endtask

    task automatic t_push(input int rl, input int ext, input string req);
        logic ill;
        int n = (rl == 15) ? 13 : rl - 3;
        logic [31:0] sp0 = 32'h0000_0100;
        logic [31:0] saved [13];
        preset(sp0);
        for (int k = 0; k < n; k++) saved[k] = rf_m[slot(k)];
        issue({8'hB8, 4'(rl), 2'(ext), 2'b10}, ill);
        finish_op();
        chk(acc_n == n, {req, " access count"}, 32'(acc_n), 32'(n));
        for (int k = 0; k < n && k < 16; k++) begin
            chk(acc_addr[k] == sp0 - 32'(4 * (k + 1)), {req, " R5 store order"}, acc_addr[k], sp0 - 32'(4 * (k + 1)));
            chk(mem_m[(sp0 - 32'(4 * (k + 1))) >> 2 & 63] == saved[k], {req, " R5 store data"},
                mem_m[(sp0 - 32'(4 * (k + 1))) >> 2 & 63], saved[k]);
        end
        chk(rf_m[2] == sp0 - 32'(frame_of(n, ext)), {req, " R6 new sp"}, rf_m[2], sp0 - 32'(frame_of(n, ext)));
        chk(done_n == 1 && jump_n == 0, {req, " R11 one done no jump"}, 32'(done_n), 32'd1);
        chk(sp_wr_cyc > last_acc_cyc, {req, " R10 sp after last access"}, 32'(sp_wr_cyc), 32'(last_acc_cyc));
    endtask

    task automatic t_pushfp();
        logic ill;
        logic [31:0] sp0 = 32'h0000_0080;
        logic [31:0] ra0;
        preset(sp0);
        ra0 = rf_m[1];
        issue(16'hB942, ill);
        finish_op();
        chk(mem_m[(sp0 - 4) >> 2 & 63] == ra0, "R8 ra stored", mem_m[(sp0 - 4) >> 2 & 63], ra0);
        chk(rf_m[8] == sp0, "R8 fp = old sp", rf_m[8], sp0);
        chk(rf_m[2] == sp0 - 32'd16, "R8 sp adjusted", rf_m[2], sp0 - 32'd16);
    endtask

    task automatic t_pop(input logic [7:0] opc, input int rl, input int ext, input string req);
        logic ill;
        int n = (rl == 15) ? 13 : rl - 3;
        logic [31:0] sp0 = 32'h0000_0080;
        logic [31:0] nsp;
        logic [31:0] a0_before;
        preset(sp0);
        nsp = sp0 + 32'(frame_of(n, ext));
        a0_before = rf_m[10];
        issue({opc, 4'(rl), 2'(ext), 2'b10}, ill);
        finish_op();
        chk(acc_n == n, {req, " R4 load count"}, 32'(acc_n), 32'(n));
        for (int k = 0; k < n && k < 16; k++) begin
            chk(acc_addr[k] == nsp - 32'(4 * (k + 1)), {req, " R7 load order"}, acc_addr[k], nsp - 32'(4 * (k + 1)));
            if (!(opc == 8'hBC && slot(k) == 5'd10))
                chk(rf_m[slot(k)] == mem_m[(nsp - 32'(4 * (k + 1))) >> 2 & 63], {req, " R7 loaded reg"},
                    rf_m[slot(k)], mem_m[(nsp - 32'(4 * (k + 1))) >> 2 & 63]);
        end
        chk(rf_m[2] == nsp, {req, " R7 new sp"}, rf_m[2], nsp);
        if (opc == 8'hBA) begin
            chk(jump_n == 0, {req, " R9 no jump on plain pop"}, 32'(jump_n), 32'd0);
            chk(rf_m[10] == a0_before, {req, " R9 a0 untouched"}, rf_m[10], a0_before);
        end else begin
            chk(jump_n == 1 && jump_seen == mem_m[(nsp - 4) >> 2 & 63], {req, " R9 jump to ra"},
                jump_seen, mem_m[(nsp - 4) >> 2 & 63]);
            if (opc == 8'hBC) chk(rf_m[10] == 32'd0, {req, " R9 a0 zero"}, rf_m[10], 32'd0);
            else chk(rf_m[10] == a0_before, {req, " R9 a0 kept"}, rf_m[10], a0_before);
        end
        chk(done_n == 1, {req, " R11 one done"}, 32'(done_n), 32'd1);
    endtask

    task automatic t_illegal(input logic [15:0] w, input logic en, input string req);
        logic ill;
        logic [31:0] sp0 = 32'h0000_0100;
        preset(sp0);
        c_enable = en;
        issue(w, ill);
        chk(ill == 1'b1, {req, " illegal pulse"}, 32'(ill), 32'd1);
        @(posedge clk); #1;
        chk(illegal == 1'b0, {req, " illegal one cycle"}, 32'(illegal), 32'd0);
        finish_op();
        chk(acc_n == 0 && done_n == 0 && rf_m[2] == sp0, {req, " no effect"}, 32'(acc_n), 32'd0);
        c_enable = 1'b1;
    endtask

    task automatic t_busy_ignore();
        logic ill;
        logic [31:0] sp0 = 32'h0000_0100;
        preset(sp0);
        issue(16'hB8F2, ill);
        @(negedge clk);
        instr = 16'hBAF2;
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        finish_op();
        chk(done_n == 1, "R11 start ignored while busy", 32'(done_n), 32'd1);
        chk(acc_n == 13 && rf_m[2] == sp0 - 32'd64, "R11 only first op ran", rf_m[2], sp0 - 32'd64);
    endtask

    task automatic t_reset_mid();
        logic ill;
        logic [31:0] sp0 = 32'h0000_0100;
        preset(sp0);
        issue(16'hB8F2, ill);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk(!busy && !mem_valid, "R12 reset aborts", {30'b0, busy, mem_valid}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        finish_op();
        chk(rf_m[2] == sp0 && done_n == 0, "R12 no sp write after abort", rf_m[2], sp0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf_m[i] = '0;
        for (int i = 0; i < 64; i++) mem_m[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;

        t_push(5, 1, "R6 push two regs extra");
        t_push(15, 0, "R4 push full list");
        t_push(14, 2, "R4 push list ending s9");
        t_pushfp();
        t_pop(8'hBA, 6, 2, "R7 pop three regs");
        t_pop(8'hBA, 15, 3, "R7 pop full list");
        t_pop(8'hBE, 4, 0, "R9 pop-return");
        t_pop(8'hBC, 4, 1, "R9 pop-return-zero");
        t_illegal(16'hB832, 1'b1, "R2 reserved list");
        t_illegal(16'hBB42, 1'b1, "R1 bad opcode byte");
        t_illegal(16'hB841, 1'b1, "R1 bad low bits");
        t_illegal(16'hB842, 1'b0, "R3 compressed disabled");
        stall = 1'b1;
        t_push(15, 1, "R10 stalled push");
        stall = 1'b0;
        t_busy_ignore();
        t_reset_mid();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule